// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This block copies the value of an external free-running timer into a holding register when a selected event appears on an asynchronous input pin. The pin first passes through a synchronizer. An edge detector and an optional edge prescaler then decide whether the current clock is a capture event. The event can be every falling edge, every rising edge, every fourth rising edge or every sixteenth rising edge. A 4-bit mode field selects the event type. Any other mode value turns capture off.

Each capture raises an interrupt flag. The flag stays set until software clears it. A later capture replaces an unread value without any error indication. The captured value is presented as a low half and a high half, which are loaded in the same clock. The halves appear on the outputs only while the read strobe is high and are zero otherwise, so several such blocks can share an OR-combined read bus.

Top module: `evtcap_top`

## Requirements
- R1: Mode encodings are 4'b0100 (every falling edge), 4'b0101 (every rising edge), 4'b0110 (every 4th rising edge) and 4'b0111 (every 16th rising edge). Any other mode value produces no capture, and the flag and the held value do not change.
- R2: The pin is synchronized by two flops. If the pin goes high before clock edge E0 and stays high, the capture happens at edge E0+2 and loads the timer value present at that edge. The flag is still low after edge E0+1.
- R3: In falling mode a rising pin edge causes no capture and a falling edge does. In rising mode the opposite holds.
- R4: In every-4th mode the 4th rising edge after a prescaler reset captures, the next capture comes 4 rising edges later, and rising edges 1 to 3 do not capture.
- R5: In every-16th mode the 16th rising edge after a prescaler reset captures, and rising edges 1 to 15 do not capture.
- R6: The prescaler count returns to zero in any clock where the mode differs from its value in the previous clock, and in any clock where the mode is not a prescaled mode.
- R7: A capture sets the flag from the next clock onward. The flag stays set until flag_clr_i is high for a clock. A capture and a clear in the same clock leave the flag set.
- R8: A capture that occurs while an earlier value is still unread replaces that value, and no other output signals the overwrite.
- R9: cap_lo_o carries bits 7:0 and cap_hi_o carries bits 15:8 of the held value while rd_stb_i is high. Both outputs are zero while rd_stb_i is low. Reading changes neither the held value nor the flag.
- R10: After reset the flag is low, the held value is zero and the prescaler count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_i | input | 16 | Current value of the free-running timer |
| pin_i | input | 1 | Asynchronous event pin |
| mode_i | input | 4 | Event-type selection |
| rd_stb_i | input | 1 | Read strobe that drives the captured halves onto the outputs |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| cap_lo_o | output | 8 | Low half of the captured value, zero when not reading |
| cap_hi_o | output | 8 | High half of the captured value, zero when not reading |
| irq_flag_o | output | 1 | Interrupt request flag |

## Verification
The hardest state to reach from the ports is a prescaler count that has restarted partway through a run of rising edges: after a mode change or a disable, a correct design needs a full four new rising edges before it captures. The stimulus sends two rising pulses in every-4th mode and then changes the mode for a single clock. It then sends exactly three more pulses, which must leave the flag low, and a fourth, which must set it. A second test raises the clear in exactly the clock where the synchronizer delivers a capture, to confirm that the set wins over the clear.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;

  // Event-type encodings on the mode field; anything else disables capture
  typedef enum logic [3:0] {
    MODE_FALL  = 4'b0100,
    MODE_RISE  = 4'b0101,
    MODE_DIV_A = 4'b0110,
    MODE_DIV_B = 4'b0111
  } evt_mode_e;

  function automatic logic mode_is_prescaled(input logic [3:0] m);
    return (m == MODE_DIV_A) || (m == MODE_DIV_B);
  endfunction

  function automatic logic mode_is_active(input logic [3:0] m);
    return (m == MODE_FALL) || (m == MODE_RISE) || mode_is_prescaled(m);
  endfunction

endpackage

// File: rtl/evtcap_sync.sv
// Flop chain for bringing a single asynchronous bit into the clock domain.
module evtcap_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  if (STAGES == 1) begin : g_single
    assign chain_d = d_i;
  end else begin : g_multi
    assign chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/evtcap_qual.sv
// Edge detection and edge prescaling: decides whether this clock captures.
module evtcap_qual
  import evtcap_pkg::*;
#(
  parameter int DIV_SMALL = 4,
  parameter int DIV_LARGE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic [3:0] mode_i,
  output logic       evt_o
);

  localparam int CW = (DIV_LARGE > 1) ? $clog2(DIV_LARGE) : 1;
  localparam logic [CW-1:0] TERM_A = CW'(DIV_SMALL - 1);
  localparam logic [CW-1:0] TERM_B = CW'(DIV_LARGE - 1);

  logic          prev_q;
  logic [3:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          rise;
  logic          fall;
  logic          prescaled;
  logic          mode_same;
  logic [CW-1:0] term;
  logic          evt;

  assign rise      = smp_i & ~prev_q;
  assign fall      = ~smp_i & prev_q;
  assign prescaled = mode_is_prescaled(mode_i);
  assign mode_same = (mode_i == mode_q);
  assign term      = (mode_i == MODE_DIV_A) ? TERM_A : TERM_B;

  // Next-state logic for the event decision and the prescaler count
  always_comb begin
    evt    = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (mode_i)
      MODE_FALL: evt = fall;
      MODE_RISE: evt = rise;
      default:   evt = 1'b0;
    endcase
    if (!prescaled || !mode_same) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (rise) begin
      cnt_en = 1'b1;
      if (cnt_q == term) begin
        cnt_d = '0;
        evt   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      mode_q <= 4'b0000;
    end else begin
      prev_q <= smp_i;
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign evt_o = evt;

endmodule

// File: rtl/evtcap_hold.sv
// Holding register and sticky interrupt flag.
module evtcap_hold #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic [TW-1:0] tmr_i,
  input  logic          clr_i,
  output logic [TW-1:0] hold_o,
  output logic          flag_o
);

  logic [TW-1:0] hold_q;
  logic          flag_q;
  logic          flag_d;
  logic          flag_en;

  // A capture takes priority over a clear in the same clock
  always_comb begin
    flag_en = evt_i | clr_i;
    flag_d  = evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (evt_i) begin
      hold_q <= tmr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign hold_o = hold_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/evtcap_top.sv
module evtcap_top
  import evtcap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_SMALL   = 4,
  parameter int DIV_LARGE   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TW-1:0]   tmr_i,
  input  logic            pin_i,
  input  logic [3:0]      mode_i,
  input  logic            rd_stb_i,
  input  logic            flag_clr_i,
  output logic [TW/2-1:0] cap_lo_o,
  output logic [TW/2-1:0] cap_hi_o,
  output logic            irq_flag_o
);

  localparam int HW = TW / 2;

  logic rst_sn;
  logic pin_s;
  logic cap_evt;
  logic [TW-1:0] hold_q;
  logic [1:0][HW-1:0] half_q;
  logic [1:0][HW-1:0] half_rd;

  // Reset: asserted at once, released after two clocks
  evtcap_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_sn)
  );

  evtcap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  evtcap_qual #(.DIV_SMALL(DIV_SMALL), .DIV_LARGE(DIV_LARGE)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .smp_i  (pin_s),
    .mode_i (mode_i),
    .evt_o  (cap_evt)
  );

  evtcap_hold #(.TW(TW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .evt_i  (cap_evt),
    .tmr_i  (tmr_i),
    .clr_i  (flag_clr_i),
    .hold_o (hold_q),
    .flag_o (irq_flag_o)
  );

  // Both halves come from one register, so they always match
  assign half_q = hold_q;

  for (genvar h = 0; h < 2; h++) begin : g_rd
    assign half_rd[h] = half_q[h] & {HW{rd_stb_i}};
  end

  assign cap_lo_o = half_rd[0];
  assign cap_hi_o = half_rd[1];

endmodule

// File: rtl/evtcap_chk.sv
module evtcap_chk
  import evtcap_pkg::*;
#(
  parameter int TW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      mode_i,
  input logic [TW-1:0]   tmr_i,
  input logic            rd_stb_i,
  input logic            flag_clr_i,
  input logic            cap_evt,
  input logic [TW-1:0]   hold_q,
  input logic            irq_flag_o,
  input logic [TW/2-1:0] cap_lo_o,
  input logic [TW/2-1:0] cap_hi_o
);

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_is_active(mode_i) |-> !cap_evt); // R1

  AST_CAP_LOADS_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (hold_q == $past(tmr_i))); // R8

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt |=> $stable(hold_q)); // R9

  AST_CAP_RAISES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> irq_flag_o); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o); // R7

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !cap_evt) |=> !irq_flag_o); // R7

  AST_READ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |-> ((cap_lo_o == '0) && (cap_hi_o == '0))); // R9

endmodule

bind evtcap_top evtcap_chk #(.TW(TW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .tmr_i      (tmr_i),
  .rd_stb_i   (rd_stb_i),
  .flag_clr_i (flag_clr_i),
  .cap_evt    (cap_evt),
  .hold_q     (hold_q),
  .irq_flag_o (irq_flag_o),
  .cap_lo_o   (cap_lo_o),
  .cap_hi_o   (cap_hi_o)
);

// File: tb/sim_evtcap_top.sv
module sim_evtcap_top;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] tmr;
  logic        pin;
  logic [3:0]  mode;
  logic        rd;
  logic        clr;
  logic [7:0]  lo;
  logic [7:0]  hi;
  logic        flag;

  int n_chk  = 0;
  int n_fail = 0;
  int wd     = 0;
  bit done   = 0;
  logic [15:0] last_rise_tmr;

  evtcap_top u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tmr_i      (tmr),
    .pin_i      (pin),
    .mode_i     (mode),
    .rd_stb_i   (rd),
    .flag_clr_i (clr),
    .cap_lo_o   (lo),
    .cap_hi_o   (hi),
    .irq_flag_o (flag)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: pin samples in a queue, rising edges counted up
  int          ph[$];
  int          m_cnt;
  int          m_prev_mode;
  bit          m_flag;
  logic [15:0] m_hold;

  always @(posedge clk) begin
    int  nw;
    int  od;
    bit  ev;
    bit  r;
    bit  f;
    int  lim;
    if (!rst_n) begin
      ph          = {0, 0, 0};
      m_cnt       = 0;
      m_prev_mode = 0;
      m_flag      = 0;
      m_hold      = 16'h0000;
    end else begin
      nw = ph[ph.size() - 2];
      od = ph[ph.size() - 3];
      r  = (nw == 1) && (od == 0);
      f  = (nw == 0) && (od == 1);
      ev = 0;
      if (mode == 4'd4 && f) ev = 1;
      if (mode == 4'd5 && r) ev = 1;
      if ((mode == 4'd6 || mode == 4'd7) && int'(mode) == m_prev_mode) begin
        lim = (mode == 4'd6) ? 4 : 16;
        if (r) m_cnt++;
        if (m_cnt == lim) begin
          ev    = 1;
          m_cnt = 0;
        end
      end else begin
        m_cnt = 0;
      end
      m_prev_mode = int'(mode);
      if (ev) begin
        m_hold = tmr;
        m_flag = 1;
      end else if (clr) begin
        m_flag = 0;
      end
      ph.push_back(int'(pin));
      if (ph.size() > 4) void'(ph.pop_front());
    end
    #(CLK_P / 4);
    chk(flag == m_flag, "R7 flag vs model", int'(flag), int'(m_flag));
    chk({hi, lo} == (rd ? m_hold : 16'h0000), "R9 read port vs model",
        int'({hi, lo}), int'(rd ? m_hold : 16'h0000));
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_fail++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    tmr = tmr + 16'h0107;
  endtask

  task automatic pulse();
    tick();
    pin = 1'b1;
    tick();
    tick();
    last_rise_tmr = tmr;
    tick();
    pin = 1'b0;
    repeat (3) tick();
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    tick();
  endtask

  task automatic read_cap(input logic [15:0] exp, input string tag);
    rd = 1'b1;
    #1;
    chk({hi, lo} == exp, tag, int'({hi, lo}), int'(exp));
    rd = 1'b0;
  endtask

  initial begin
    logic [15:0] first_val;
    logic [15:0] exp_val;
    rst_n = 1'b0;
    tmr   = 16'h1234;
    pin   = 1'b0;
    mode  = 4'b0000;
    rd    = 1'b0;
    clr   = 1'b0;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (5) tick();

    // R10: reset state
    chk(flag == 1'b0, "R10 flag after reset", int'(flag), 0);
    read_cap(16'h0000, "R10 held value after reset");
    chk({hi, lo} == 16'h0000, "R9 outputs zero without strobe", int'({hi, lo}), 0);

    // R1: inactive mode values capture nothing
    mode = 4'b0000;
    pulse();
    pulse();
    chk(flag == 1'b0, "R1 mode 0000 no capture", int'(flag), 0);
    mode = 4'b1101;
    pulse();
    chk(flag == 1'b0, "R1 mode 1101 no capture", int'(flag), 0);
    mode = 4'b0011;
    pulse();
    chk(flag == 1'b0, "R1 mode 0011 no capture", int'(flag), 0);
    read_cap(16'h0000, "R1 value untouched");

    // R2: two-flop latency, rising mode
    mode = 4'b0101;
    repeat (3) tick();
    tick();
    pin = 1'b1;
    tick();
    tick();
    chk(flag == 1'b0, "R2 no capture after E0+1", int'(flag), 0);
    exp_val = tmr;
    tick();
    chk(flag == 1'b1, "R2 capture at E0+2", int'(flag), 1);
    read_cap(exp_val, "R2 timer value at E0+2");
    repeat (3) tick();
    pin = 1'b0;
    repeat (4) tick();
    chk(flag == 1'b1, "R7 flag sticky", int'(flag), 1);
    clear_flag();
    chk(flag == 1'b0, "R7 flag cleared", int'(flag), 0);

    // R3: falling mode ignores rise, captures on fall
    mode = 4'b0100;
    repeat (3) tick();
    tick();
    pin = 1'b1;
    repeat (4) tick();
    chk(flag == 1'b0, "R3 rise ignored in falling mode", int'(flag), 0);
    pin = 1'b0;
    tick();
    tick();
    exp_val = tmr;
    tick();
    chk(flag == 1'b1, "R3 fall captured", int'(flag), 1);
    read_cap(exp_val, "R3 value on fall");
    clear_flag();
    mode = 4'b0101;
    tick();
    pin = 1'b1;
    repeat (3) tick();
    clear_flag();
    pin = 1'b0;
    repeat (4) tick();
    chk(flag == 1'b0, "R3 fall ignored in rising mode", int'(flag), 0);

    // R4: every 4th rising edge
    mode = 4'b0110;
    tick();
    clear_flag();
    for (int i = 0; i < 3; i++) pulse();
    chk(flag == 1'b0, "R4 three rises no capture", int'(flag), 0);
    pulse();
    chk(flag == 1'b1, "R4 fourth rise captures", int'(flag), 1);
    read_cap(last_rise_tmr, "R4 value on fourth rise");
    clear_flag();
    for (int i = 0; i < 3; i++) pulse();
    chk(flag == 1'b0, "R4 next three rises no capture", int'(flag), 0);
    pulse();
    chk(flag == 1'b1, "R4 eighth rise captures", int'(flag), 1);

    // R5: every 16th rising edge
    mode = 4'b0111;
    tick();
    clear_flag();
    for (int i = 0; i < 15; i++) pulse();
    chk(flag == 1'b0, "R5 fifteen rises no capture", int'(flag), 0);
    pulse();
    chk(flag == 1'b1, "R5 sixteenth rise captures", int'(flag), 1);

    // R6: count restarts on a one-clock mode change
    mode = 4'b0110;
    tick();
    clear_flag();
    pulse();
    pulse();
    mode = 4'b0111;
    tick();
    mode = 4'b0110;
    tick();
    for (int i = 0; i < 3; i++) pulse();
    chk(flag == 1'b0, "R6 restart after mode change", int'(flag), 0);
    pulse();
    chk(flag == 1'b1, "R6 fourth rise after restart", int'(flag), 1);
    clear_flag();
    pulse();
    pulse();
    mode = 4'b0000;
    tick();
    tick();
    mode = 4'b0110;
    tick();
    for (int i = 0; i < 3; i++) pulse();
    chk(flag == 1'b0, "R6 restart after disable", int'(flag), 0);
    pulse();
    chk(flag == 1'b1, "R6 fourth rise after disable", int'(flag), 1);

    // R7: capture and clear in the same clock, set wins
    mode = 4'b0101;
    tick();
    clear_flag();
    tick();
    pin = 1'b1;
    tick();
    tick();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    chk(flag == 1'b1, "R7 set wins over clear", int'(flag), 1);
    repeat (2) tick();
    pin = 1'b0;
    repeat (3) tick();

    // R8: overwrite of an unread value
    clear_flag();
    pulse();
    first_val = last_rise_tmr;
    pulse();
    chk(flag == 1'b1, "R8 flag after two captures", int'(flag), 1);
    read_cap(last_rise_tmr, "R8 newest value kept");
    chk(last_rise_tmr != first_val, "R8 values differ", int'(last_rise_tmr), int'(first_val));

    // R9: reading leaves value and flag alone
    rd = 1'b1;
    tick();
    tick();
    rd = 1'b0;
    tick();
    chk(flag == 1'b1, "R9 flag unchanged by read", int'(flag), 1);
    read_cap(last_rise_tmr, "R9 value unchanged by read");

    repeat (4) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule